// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Controller

This block keeps the status byte of a small serial flash model and rules on every decoded command: whether it runs or is refused. A command arrives as a one-cycle valid strobe with an operation code, a target byte address and, for the status write, a data byte. One cycle later the block answers with exactly one of accept or reject. For an accepted status write, page program, sector erase, block erase or full-array erase, it also raises a start pulse with the operation's code toward an external array timer. The block then stays busy until that timer returns a one-cycle done pulse.

Write-class commands need the write-enable latch to be set, and the latch falls automatically when an accepted operation finishes. A three-bit protection code marks the top part of the address space as locked. Program and erase aimed inside it are refused, and the full-array erase runs only when the code is zero. A status-lock bit combines with a write-protect input to freeze the status register. In one-time-programmable mode the same bit locks every write-class command. The protection code and the lock bit are written only when a status-write cycle completes.

The control is a three-state machine. ST_IDLE is the resting state. Its transition IDLE_TO_STAT is taken on an accepted status write and leads to ST_STAT_BUSY. Its transition IDLE_TO_ARRAY is taken on an accepted program or erase and leads to ST_ARRAY_BUSY. From either busy state, the transition DONE_TO_IDLE is taken on the done pulse and returns to ST_IDLE. Leaving ST_STAT_BUSY this way also commits the buffered status value.

Top module: `sfl_status_ctrl`

## Requirements
- R1: The status byte is {lock, 0, 0, code[2:0], latch, busy}: bit 7 is the status-lock bit, bits 6:5 always read 0, bits 4:2 hold the protection code with its top bit at bit 4, bit 1 is the write-enable latch, and bit 0 is the busy flag. After reset it equals {LOCK_INIT, 2'b00, CODE_INIT, 2'b00}.
- R2: A write-on command sets the latch and a write-off command clears it, visible in the cycle after the command. Both are accepted only when not busy.
- R3: While the latch is 0, status write, program, sector erase, block erase and full erase are rejected, raise no start pulse and change no status bit. Any rejected command leaves the latch as it was.
- R4: An accepted status write raises a start pulse with the status-write code and shows busy from the next cycle. The lock bit takes data bit 7 and the code takes data bits 4:2 only in the cycle after the done pulse; data bits 6:5 and 1:0 are ignored.
- R5: When the lock bit is 1 and the write-protect input is 1, a status write is rejected and the lock bit and code stay unchanged. The write-protect input has no effect on program or erase.
- R6: Program, sector erase and block erase are rejected when the address lies in the locked region and accepted otherwise. Code 0 locks nothing and code 7 locks everything. Code c from 1 to 6 locks the addresses whose top k address bits are all ones, with k taken from the region table entry for c. The default table gives k = 7 - c, so code 1 locks the top 1/64 and code 5 the top quarter.
- R7: Full erase is accepted only when the protection code is 000, whatever the address. Any non-zero code makes it rejected.
- R8: While busy, every command except the status read is rejected and changes nothing. In the cycle after the done pulse, busy and the latch both read 0. A done pulse while idle has no effect.
- R9: The status read is accepted in every state, including busy, and the status output always shows the live busy flag.
- R10: Command codes are 0 status read, 1 write-on, 2 write-off, 3 status write, 4 program, 5 sector erase, 6 block erase, 7 full erase. Each valid command produces exactly one of accept or reject in the next cycle. The start pulse appears in that same cycle only for accepted codes 3 to 7, and the kind output then carries the command code.
- R11: With the one-time-programmable mode input at 1 and the lock bit at 1, every code from 3 to 7 is rejected. With the mode input at 0, the lock bit matters only together with write-protect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | One-cycle command strobe |
| cmd_op_i | input | 3 | Command code |
| cmd_addr_i | input | ADDR_W | Target byte address |
| cmd_data_i | input | 8 | New status value for a status write |
| wp_i | input | 1 | Write-protect input, active high |
| otp_mode_i | input | 1 | One-time-programmable mode select |
| op_done_i | input | 1 | Done pulse from the array timer |
| status_o | output | 8 | Live status byte |
| cmd_accept_o | output | 1 | Command accepted, one cycle after the strobe |
| cmd_reject_o | output | 1 | Command refused, one cycle after the strobe |
| op_start_o | output | 1 | Start pulse for the array timer |
| op_kind_o | output | 3 | Code of the started operation |

## Verification
The bench builds the block with a 12-bit address and a reset protection code of 7. The first checks therefore meet a fully locked array before any status write has happened. A 4096-byte space puts the region edges for code 5 (3072) and code 1 (4032) at addresses that can be probed exactly one below and at the boundary. The default region table is kept, so the generated comparator for every non-trivial code is taken from the parameter rather than from a special case.

// File: rtl/sfl_status_pkg.sv
package sfl_status_pkg;

    localparam int unsigned CMD_W  = 3;
    localparam int unsigned CODE_W = 3;
    localparam int unsigned STAT_W = 8;

    // command codes: the ordering is part of the external interface
    typedef enum logic [CMD_W-1:0] {
        CMD_READ_STAT  = 3'd0,
        CMD_WR_ON      = 3'd1,
        CMD_WR_OFF     = 3'd2,
        CMD_STAT_WRITE = 3'd3,
        CMD_PROGRAM    = 3'd4,
        CMD_SECT_ERASE = 3'd5,
        CMD_BLK_ERASE  = 3'd6,
        CMD_FULL_ERASE = 3'd7
    } sfl_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_STAT_BUSY  = 2'd1,
        ST_ARRAY_BUSY = 2'd2
    } sfl_state_e;

    // status byte bit positions
    localparam int unsigned POS_BUSY  = 0;
    localparam int unsigned POS_LATCH = 1;
    localparam int unsigned POS_CODE  = 2;
    localparam int unsigned POS_LOCK  = 7;

    function automatic logic is_write_class(input sfl_cmd_e op);
        return (op == CMD_STAT_WRITE) || (op == CMD_PROGRAM) ||
               (op == CMD_SECT_ERASE) || (op == CMD_BLK_ERASE) ||
               (op == CMD_FULL_ERASE);
    endfunction

endpackage

// File: rtl/sfl_region_guard.sv
module sfl_region_guard
    import sfl_status_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned TBL_W    = 4,
    // entry c-1 holds k for code c (1..6): top k address bits all ones
    parameter logic [6*TBL_W-1:0] REGION_TBL = {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6}
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              locked_o
);

    localparam int unsigned N_CODES = 1 << CODE_W;

    logic [N_CODES-1:0] hit;
    logic               unused_addr;

    assign unused_addr = ^addr_i;

    for (genvar c = 0; c < N_CODES; c++) begin : g_code
        if (c == 0) begin : g_none
            assign hit[c] = 1'b0;
        end else if (c == N_CODES - 1) begin : g_all
            assign hit[c] = 1'b1;
        end else begin : g_part
            localparam int unsigned K = int'(REGION_TBL[(c-1)*TBL_W +: TBL_W]);
            assign hit[c] = &addr_i[ADDR_W-1 -: K];
        end
    end

    assign locked_o = hit[code_i];

endmodule

// File: rtl/sfl_cmd_policy.sv
module sfl_cmd_policy
    import sfl_status_pkg::*;
(
    input  sfl_cmd_e          op_i,
    input  logic              idle_i,
    input  logic              latch_i,
    input  logic              lock_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              wp_i,
    input  logic              otp_mode_i,
    input  logic              addr_locked_i,
    output logic              permit_o,
    output logic              launch_o
);

    logic hw_frozen;
    logic otp_locked;
    logic may_write;

    assign hw_frozen  = lock_i & wp_i;
    assign otp_locked = lock_i & otp_mode_i;
    assign may_write  = idle_i & latch_i & ~otp_locked;

    always_comb begin
        permit_o = 1'b0;
        unique case (op_i)
            CMD_READ_STAT:  permit_o = 1'b1;
            CMD_WR_ON,
            CMD_WR_OFF:     permit_o = idle_i;
            CMD_STAT_WRITE: permit_o = may_write & ~hw_frozen;
            CMD_PROGRAM,
            CMD_SECT_ERASE,
            CMD_BLK_ERASE:  permit_o = may_write & ~addr_locked_i;
            CMD_FULL_ERASE: permit_o = may_write & (code_i == '0);
            default:        permit_o = 1'b0;
        endcase
    end

    assign launch_o = permit_o & is_write_class(op_i);

endmodule

// File: rtl/sfl_op_fsm.sv
module sfl_op_fsm
    import sfl_status_pkg::*;
#(
    parameter logic              LOCK_INIT = 1'b0,
    parameter logic [CODE_W-1:0] CODE_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  sfl_cmd_e          cmd_op_i,
    input  logic [STAT_W-1:0] cmd_data_i,
    input  logic              permit_i,
    input  logic              launch_i,
    input  logic              op_done_i,
    output logic              idle_o,
    output logic              busy_o,
    output logic              latch_o,
    output logic              lock_o,
    output logic [CODE_W-1:0] code_o,
    output logic              accept_o,
    output logic              reject_o,
    output logic              start_o,
    output sfl_cmd_e          kind_o
);

    sfl_state_e        state_q, state_d;
    logic              pend_lock_q;
    logic [CODE_W-1:0] pend_code_q;
    logic              take;
    logic              go;
    logic              finish;
    logic              unused_data;

    assign take        = cmd_valid_i & permit_i;
    assign go          = cmd_valid_i & launch_i;
    assign finish      = (state_q != ST_IDLE) & op_done_i;
    assign unused_data = ^{cmd_data_i[6:5], cmd_data_i[1:0]};

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) begin
                    // IDLE_TO_STAT / IDLE_TO_ARRAY
                    state_d = (cmd_op_i == CMD_STAT_WRITE) ? ST_STAT_BUSY : ST_ARRAY_BUSY;
                end
            end
            ST_STAT_BUSY,
            ST_ARRAY_BUSY: begin
                if (op_done_i) state_d = ST_IDLE; // DONE_TO_IDLE
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and status fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept_o    <= 1'b0;
            reject_o    <= 1'b0;
            start_o     <= 1'b0;
            kind_o      <= CMD_READ_STAT;
            latch_o     <= 1'b0;
            lock_o      <= LOCK_INIT;
            code_o      <= CODE_INIT;
            pend_lock_q <= 1'b0;
            pend_code_q <= '0;
        end else begin
            accept_o <= take;
            reject_o <= cmd_valid_i & ~permit_i;
            start_o  <= go;
            if (go) kind_o <= cmd_op_i;

            if (take && cmd_op_i == CMD_WR_ON)  latch_o <= 1'b1;
            if (take && cmd_op_i == CMD_WR_OFF) latch_o <= 1'b0;
            if (finish)                         latch_o <= 1'b0;

            if (take && cmd_op_i == CMD_STAT_WRITE) begin
                pend_lock_q <= cmd_data_i[POS_LOCK];
                pend_code_q <= cmd_data_i[POS_CODE +: CODE_W];
            end
            if (state_q == ST_STAT_BUSY && op_done_i) begin
                lock_o <= pend_lock_q;
                code_o <= pend_code_q;
            end
        end
    end

    assign idle_o = (state_q == ST_IDLE);
    assign busy_o = ~idle_o;

    AST_START_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(latch_o)); // R3

    AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_i |=> (accept_o ^ reject_o)); // R10

    AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cmd_valid_i && cmd_op_i != CMD_READ_STAT) |=> reject_o); // R8

    AST_READ_ALWAYS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_op_i == CMD_READ_STAT) |=> accept_o); // R9

    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q == ST_STAT_BUSY && op_done_i) |=> $stable(code_o)); // R4

    AST_FULL_ERASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && kind_o == CMD_FULL_ERASE) |-> ($past(code_o) == '0)); // R7

    AST_LATCH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> (!latch_o && idle_o)); // R8

endmodule

// File: rtl/sfl_status_ctrl.sv
module sfl_status_ctrl
    import sfl_status_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 16,
    parameter int unsigned       TBL_W      = 4,
    parameter logic [6*TBL_W-1:0] REGION_TBL = {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6},
    parameter logic              LOCK_INIT  = 1'b0,
    parameter logic [2:0]        CODE_INIT  = 3'b000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic [2:0]        cmd_op_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [7:0]        cmd_data_i,
    input  logic              wp_i,
    input  logic              otp_mode_i,
    input  logic              op_done_i,
    output logic [7:0]        status_o,
    output logic              cmd_accept_o,
    output logic              cmd_reject_o,
    output logic              op_start_o,
    output logic [2:0]        op_kind_o
);

    sfl_cmd_e          op;
    sfl_cmd_e          kind;
    logic              addr_locked;
    logic              permit;
    logic              launch;
    logic              idle;
    logic              busy;
    logic              latch;
    logic              lock;
    logic [CODE_W-1:0] code;

    assign op = sfl_cmd_e'(cmd_op_i);

    sfl_region_guard #(
        .ADDR_W     (ADDR_W),
        .TBL_W      (TBL_W),
        .REGION_TBL (REGION_TBL)
    ) u_guard (
        .addr_i   (cmd_addr_i),
        .code_i   (code),
        .locked_o (addr_locked)
    );

    sfl_cmd_policy u_policy (
        .op_i          (op),
        .idle_i        (idle),
        .latch_i       (latch),
        .lock_i        (lock),
        .code_i        (code),
        .wp_i          (wp_i),
        .otp_mode_i    (otp_mode_i),
        .addr_locked_i (addr_locked),
        .permit_o      (permit),
        .launch_o      (launch)
    );

    sfl_op_fsm #(
        .LOCK_INIT (LOCK_INIT),
        .CODE_INIT (CODE_INIT)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid_i (cmd_valid_i),
        .cmd_op_i    (op),
        .cmd_data_i  (cmd_data_i),
        .permit_i    (permit),
        .launch_i    (launch),
        .op_done_i   (op_done_i),
        .idle_o      (idle),
        .busy_o      (busy),
        .latch_o     (latch),
        .lock_o      (lock),
        .code_o      (code),
        .accept_o    (cmd_accept_o),
        .reject_o    (cmd_reject_o),
        .start_o     (op_start_o),
        .kind_o      (kind)
    );

    assign op_kind_o = kind;

    always_comb begin
        status_o                          = '0;
        status_o[POS_LOCK]                = lock;
        status_o[POS_CODE +: CODE_W]      = code;
        status_o[POS_LATCH]               = latch;
        status_o[POS_BUSY]                = busy;
    end

    AST_START_WITH_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        op_start_o |-> cmd_accept_o); // R10

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6:5] == 2'b00); // R1

endmodule

// File: tb/sfl_status_ctrl_test.sv
`timescale 1ns/1ps
module sfl_status_ctrl_test;

    localparam int AW = 12;
    localparam logic [2:0] RD = 3'd0, WON = 3'd1, WOFF = 3'd2, SWR = 3'd3,
                           PRG = 3'd4, SER = 3'd5, BER = 3'd6, FER = 3'd7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [7:0]    cmd_data = '0;
    logic          wp = 1'b0;
    logic          otp = 1'b0;
    logic          op_done = 1'b0;
    logic [7:0]    status;
    logic          acc, rej, start;
    logic [2:0]    kind;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    typedef struct packed {
        logic       acc;
        logic       start;
        logic [2:0] kind;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    sfl_status_ctrl #(
        .ADDR_W    (AW),
        .LOCK_INIT (1'b0),
        .CODE_INIT (3'b111)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid_i  (cmd_valid),
        .cmd_op_i     (cmd_op),
        .cmd_addr_i   (cmd_addr),
        .cmd_data_i   (cmd_data),
        .wp_i         (wp),
        .otp_mode_i   (otp),
        .op_done_i    (op_done),
        .status_o     (status),
        .cmd_accept_o (acc),
        .cmd_reject_o (rej),
        .op_start_o   (start),
        .op_kind_o    (kind)
    );

    // driver: pushes the expected answer, then strobes the command
    task automatic issue(input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [7:0] d, input logic exp_acc, input string tag);
        exp_t e;
        @(negedge clk);
        e.acc   = exp_acc;
        e.start = exp_acc && (op >= SWR);
        e.kind  = op;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = a;
        cmd_data  = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    task automatic check_status(input logic [7:0] exp, input string tag);
        n_checks++;
        if (status !== exp) begin
            n_errors++;
            $display("FAIL %s status: got %h expected %h", tag, status, exp);
        end
    endtask

    // monitor: pops and compares each answer
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (acc || rej) begin
                if (exp_q.size() == 0) begin
                    n_checks++;
                    n_errors++;
                    $display("FAIL R10 unexpected answer: got acc=%b rej=%b expected none", acc, rej);
                end else begin
                    exp_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    n_checks++;
                    if (acc !== e.acc || rej !== !e.acc || start !== e.start ||
                        (e.start && kind !== e.kind)) begin
                        n_errors++;
                        $display("FAIL %s answer: got acc=%b rej=%b start=%b kind=%0d expected acc=%b start=%b kind=%0d",
                                 t, acc, rej, start, kind, e.acc, e.start, e.kind);
                    end
                end
            end else if (start) begin
                n_checks++;
                n_errors++;
                $display("FAIL R10 start without answer: got start=1 expected 0");
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_status(8'h1C, "R1 reset");

        issue(PRG, 12'd0, 8'h00, 1'b0, "R3 program without latch");
        check_status(8'h1C, "R3");
        issue(WON, 12'd0, 8'h00, 1'b1, "R2 write-on");
        check_status(8'h1E, "R2");
        issue(FER, 12'd0, 8'h00, 1'b0, "R7 full erase code 7");
        check_status(8'h1E, "R7 latch kept");
        issue(PRG, 12'd0, 8'h00, 1'b0, "R6 code 7 locks all");

        issue(SWR, 12'd0, 8'h00, 1'b1, "R4 status write");
        check_status(8'h1F, "R4 busy, old code");
        issue(RD, 12'd0, 8'h00, 1'b1, "R9 read while busy");
        check_status(8'h1F, "R9 live busy");
        issue(WOFF, 12'd0, 8'h00, 1'b0, "R8 write-off while busy");
        check_status(8'h1F, "R8 unchanged while busy");
        done_pulse();
        check_status(8'h00, "R4 commit / R8 done");
        done_pulse();
        check_status(8'h00, "R8 done while idle");

        issue(WON, 12'd0, 8'h00, 1'b1, "R2");
        issue(SWR, 12'd0, 8'hF7, 1'b1, "R4 write F7");
        check_status(8'h03, "R4 not yet committed");
        done_pulse();
        check_status(8'h94, "R4 ignored bits");

        issue(WON, 12'd0, 8'h00, 1'b1, "R2");
        check_status(8'h96, "R2");
        issue(PRG, 12'd3071, 8'h00, 1'b1, "R6 below quarter edge");
        check_status(8'h97, "R6 busy");
        done_pulse();
        check_status(8'h94, "R8 latch cleared");
        issue(WON, 12'd0, 8'h00, 1'b1, "R2");
        issue(SER, 12'd3072, 8'h00, 1'b0, "R6 quarter edge");
        issue(BER, 12'd4095, 8'h00, 1'b0, "R6 top address");
        check_status(8'h96, "R3 latch kept after reject");

        wp = 1'b1;
        issue(SWR, 12'd0, 8'h00, 1'b0, "R5 frozen status write");
        check_status(8'h96, "R5 unchanged");
        issue(PRG, 12'd0, 8'h00, 1'b1, "R5 program ignores wp");
        done_pulse();
        check_status(8'h94, "R5");
        wp = 1'b0;

        otp = 1'b1;
        issue(WON, 12'd0, 8'h00, 1'b1, "R11 write-on");
        issue(PRG, 12'd0, 8'h00, 1'b0, "R11 otp program");
        issue(SWR, 12'd0, 8'h00, 1'b0, "R11 otp status write");
        check_status(8'h96, "R11");
        otp = 1'b0;

        issue(SWR, 12'd0, 8'h04, 1'b1, "R4 code 1");
        done_pulse();
        check_status(8'h04, "R4 code 1");
        issue(WON, 12'd0, 8'h00, 1'b1, "R2");
        issue(PRG, 12'd4031, 8'h00, 1'b1, "R6 below 1/64 edge");
        done_pulse();
        issue(WON, 12'd0, 8'h00, 1'b1, "R2");
        issue(PRG, 12'd4032, 8'h00, 1'b0, "R6 1/64 edge");
        check_status(8'h06, "R6");
        issue(FER, 12'd0, 8'h00, 1'b0, "R7 full erase code 1");

        issue(SWR, 12'd0, 8'h00, 1'b1, "R4 clear");
        done_pulse();
        check_status(8'h00, "R4 cleared");
        issue(WON, 12'd0, 8'h00, 1'b1, "R2");
        issue(FER, 12'd100, 8'h00, 1'b1, "R7 full erase code 0");
        done_pulse();
        check_status(8'h00, "R7 done");
        issue(WON, 12'd0, 8'h00, 1'b1, "R2");
        issue(WOFF, 12'd0, 8'h00, 1'b1, "R2 write-off");
        check_status(8'h00, "R2 latch off");

        repeat (2) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_errors++;
            $display("FAIL R10 missing answers: got %0d pending expected 0", exp_q.size());
        end
        finished = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule